// File: doc/BRIEF.md
# Command Queue Execution Thread

This block is one hardware thread of a command engine that plays back a list of 64-bit instructions held in memory, so that a group of register writes lands on target subsystems at a precise moment, for example while a display is in blanking. The thread fetches one instruction at a time through a simple request/valid memory port. It issues masked register writes, follows relative and absolute jumps, blocks on hardware event flags and clears them, and raises interrupts when it finishes or faults.

Software drives the thread through a small register window. It sets an end address and a start address, enables the thread and later collects a done or an error interrupt. A program can be paused and resumed part-way through. Rewriting the current address throws away whatever was already fetched and restarts at that address, which lets software patch a running program.

Top module: `cq_thread`

## Requirements
- R1: After reset every register in the window reads 0, `irq` is low and no fetch is requested.
- R2: An instruction whose upper word has opcode 0x04 in bits [31:24] produces exactly one `tgt_we` pulse carrying the subsystem from upper bits [20:16], the offset from upper bits [15:0] and the data from the lower word; writes leave the thread in program order.
- R3: Opcode 0x10 jumps: with upper bit 0 set, to the absolute address in the lower word; with upper bit 0 clear, to the current address plus the lower word. Instructions that are skipped are never executed.
- R4: Opcode 0x02 loads the lower word as a write mask. The next write presents that mask on `tgt_mask`, and every later write presents all ones until another mask load.
- R5: Opcode 0x20 uses the event number in the low upper bits, lower bit 15 as wait, lower bit 0 as the wanted value and lower bit 31 as update. With wait set, the thread stalls while the flag differs from the wanted value, and bit 31 of register 0x30 reads 1 during the stall. With update set, one `evt_clr` pulse is given for that event once the instruction completes; with wait clear it only clears.
- R6: Writing 1 to bit 0 of register 0x08 stops execution and freezes the current address, and bit 1 of register 0x0C reads 1; writing 0 resumes from the current address.
- R7: When the current address (0x20) equals the end address (0x24) on an enabled thread, it stops and sets bit 0 of the interrupt status (0x10). `irq` is high whenever a status bit is set whose enable bit (0x14) is set.
- R8: Only status bits 0, 1 and 4 exist. Writing 0 to a bit clears it; writing 1 leaves it unchanged.
- R9: Writing register 0x20 discards any buffered or in-flight fetch, restarts fetching at the written address and releases a stopped thread.
- R10: An undefined opcode sets status bit 1 and halts with the current address still pointing at the faulting instruction.
- R11: A fetch answered with `mem_err` sets status bit 4 and halts at that address.
- R12: Writing 1 to bit 0 of register 0x00 starts a warm reset; the bit reads 1 for RST_CYC cycles and then 0, and the reset clears enable, suspend, both addresses and the status bits.
- R13: Opcode 0x40 with lower bit 0 set raises status bit 0 and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register window write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on `cfg_addr`) |
| mem_req | output | 1 | Instruction fetch request, one cycle per fetch |
| mem_addr | output | AW | Byte address of the fetch |
| mem_valid | input | 1 | Fetch response valid |
| mem_data | input | 64 | Fetched instruction |
| mem_err | input | 1 | Fetch response carries an error |
| tgt_we | output | 1 | Target register write strobe |
| tgt_subsys | output | 5 | Target subsystem |
| tgt_offs | output | 16 | Target register offset |
| tgt_data | output | 32 | Target write data |
| tgt_mask | output | 32 | Bits of the target register to update |
| evt_flags | input | NEV | Hardware event flags |
| evt_clr | output | NEV | One-cycle clear pulse per event |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, so its readback and the start of fetching are both checked from the following cycle. Each instruction costs one request cycle, the memory latency and one execute cycle, and the target write and event clear appear during that execute cycle; the bench's memory answers three cycles after a request, and the reference model keeps the expected writes in a queue that is compared on every falling edge, so any write at the wrong time, in the wrong order or with the wrong mask is caught where it happens. Results that depend on a whole program, such as the end address, status bits and the interrupt line, are read only after a settling window well beyond the program length, and the stale-fetch case places the second address write exactly while the first fetch is outstanding.

// File: rtl/cq_pkg.sv
package cq_pkg;
   localparam logic [7:0] OP_MASK  = 8'h02;
   localparam logic [7:0] OP_WRITE = 8'h04;
   localparam logic [7:0] OP_JUMP  = 8'h10;
   localparam logic [7:0] OP_WFE   = 8'h20;
   localparam logic [7:0] OP_EOC   = 8'h40;

   localparam int INSTR_BYTES = 8;

   localparam logic [7:0] REG_WRST  = 8'h00;
   localparam logic [7:0] REG_EN    = 8'h04;
   localparam logic [7:0] REG_SUSP  = 8'h08;
   localparam logic [7:0] REG_STAT  = 8'h0C;
   localparam logic [7:0] REG_IRQ   = 8'h10;
   localparam logic [7:0] REG_IRQEN = 8'h14;
   localparam logic [7:0] REG_CUR   = 8'h20;
   localparam logic [7:0] REG_END   = 8'h24;
   localparam logic [7:0] REG_WTOK  = 8'h30;
   localparam logic [7:0] REG_PRIO  = 8'h40;

   localparam logic [4:0] IRQ_BITS = 5'b10011;

   typedef enum logic [2:0] {
      K_MASK, K_WRITE, K_JUMP, K_WFE, K_EOC, K_BAD
   } cq_kind_e;
endpackage

// File: rtl/cq_decode.sv
module cq_decode
   import cq_pkg::*;
#(
   parameter int EVW = 5
) (
   input  logic [63:0]    instr,
   output cq_kind_e       kind,
   output logic           jmp_abs,
   output logic [4:0]     subsys,
   output logic [15:0]    offs,
   output logic [31:0]    imm,
   output logic [EVW-1:0] ev_id,
   output logic           wfe_wait,
   output logic           wfe_upd,
   output logic           wfe_val
);
   always_comb begin
      unique case (instr[63:56])
         OP_MASK:  kind = K_MASK;
         OP_WRITE: kind = K_WRITE;
         OP_JUMP:  kind = K_JUMP;
         OP_WFE:   kind = K_WFE;
         OP_EOC:   kind = K_EOC;
         default:  kind = K_BAD;
      endcase
   end

   assign jmp_abs  = instr[32];
   assign subsys   = instr[52:48];
   assign offs     = instr[47:32];
   assign imm      = instr[31:0];
   assign ev_id    = instr[32 +: EVW];
   assign wfe_upd  = instr[31];
   assign wfe_wait = instr[15];
   assign wfe_val  = instr[0];
endmodule

// File: rtl/cq_fetch.sv
module cq_fetch #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          flush,
   input  logic [AW-1:0] pc,
   input  logic          take,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_valid,
   input  logic [63:0]   mem_data,
   input  logic          mem_err,
   output logic          buf_vld,
   output logic [63:0]   buf_data,
   output logic          buf_err
);
   logic pend_q, stale_q;

   assign mem_req  = run && !flush && !pend_q && !buf_vld;
   assign mem_addr = pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         stale_q  <= 1'b0;
         buf_vld  <= 1'b0;
         buf_data <= '0;
         buf_err  <= 1'b0;
      end else begin
         if (mem_req)        pend_q <= 1'b1;
         else if (mem_valid) pend_q <= 1'b0;

         if (flush && pend_q && !mem_valid) stale_q <= 1'b1;
         else if (mem_valid)                stale_q <= 1'b0;

         if (flush || take) begin
            buf_vld <= 1'b0;
         end else if (mem_valid && !stale_q) begin
            buf_vld  <= 1'b1;
            buf_data <= mem_data;
            buf_err  <= mem_err;
         end
      end
   end

   // R9: a flush leaves the buffer empty on the next cycle
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !buf_vld);
   // R9: responses only arrive for an outstanding request
   a_r9_resp_pending: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> pend_q);
endmodule

// File: rtl/cq_thread.sv
module cq_thread
   import cq_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NEV     = 32,
   parameter int RST_CYC = 4,
   parameter int PRIO_W  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [7:0]     cfg_addr,
   input  logic [31:0]    cfg_wdata,
   output logic [31:0]    cfg_rdata,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_valid,
   input  logic [63:0]    mem_data,
   input  logic           mem_err,
   output logic           tgt_we,
   output logic [4:0]     tgt_subsys,
   output logic [15:0]    tgt_offs,
   output logic [31:0]    tgt_data,
   output logic [31:0]    tgt_mask,
   input  logic [NEV-1:0] evt_flags,
   output logic [NEV-1:0] evt_clr,
   output logic           irq
);
   localparam int EVW = $clog2(NEV);
   localparam int RCW = $clog2(RST_CYC + 1);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("cq_thread: AW must be 8..32");
   end
   if (NEV < 2 || (1 << EVW) != NEV) begin : g_bad_nev
      $error("cq_thread: NEV must be a power of two >= 2");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("cq_thread: RST_CYC must be >= 1");
   end

   logic              en_q, susp_q, stop_q;
   logic [PRIO_W-1:0] prio_q;
   logic [4:0]        irq_st_q, irq_en_q;
   logic [AW-1:0]     pc_q, end_q;
   logic [31:0]       mask_q;
   logic [RCW-1:0]    rcnt_q;

   logic              buf_vld, buf_err;
   logic [63:0]       buf_data;
   cq_kind_e          kind;
   logic              jmp_abs, wfe_wait, wfe_upd, wfe_val;
   logic [31:0]       imm;
   logic [EVW-1:0]    ev_id;

   logic rst_busy, cur_wr, run, flush, exec, stall, fire;
   logic fault_fetch, fault_op, done_hit, eoc_irq, clr_fire, wait_tok;
   logic [AW-1:0] pc_nxt;
   logic [4:0]    irq_set;

   assign rst_busy = rcnt_q != '0;
   assign cur_wr   = cfg_we && cfg_addr == REG_CUR && !rst_busy;
   assign run      = en_q && !susp_q && !stop_q && !rst_busy && !cur_wr && pc_q != end_q;
   assign flush    = rst_busy || cur_wr;

   cq_fetch #(.AW(AW)) i_fetch (
      .clk(clk), .rst_n(rst_n), .run(run), .flush(flush), .pc(pc_q), .take(fire),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_data(mem_data), .mem_err(mem_err),
      .buf_vld(buf_vld), .buf_data(buf_data), .buf_err(buf_err)
   );

   cq_decode #(.EVW(EVW)) i_decode (
      .instr(buf_data), .kind(kind), .jmp_abs(jmp_abs), .subsys(tgt_subsys),
      .offs(tgt_offs), .imm(imm), .ev_id(ev_id), .wfe_wait(wfe_wait),
      .wfe_upd(wfe_upd), .wfe_val(wfe_val)
   );

   assign exec        = run && buf_vld;
   assign stall       = kind == K_WFE && wfe_wait && (evt_flags[ev_id] != wfe_val);
   assign fault_fetch = exec && buf_err;
   assign fault_op    = exec && !buf_err && kind == K_BAD;
   assign fire        = exec && !buf_err && kind != K_BAD && !stall;
   assign wait_tok    = exec && !buf_err && stall;
   assign done_hit    = en_q && !stop_q && !rst_busy && !cur_wr && pc_q == end_q;
   assign eoc_irq     = fire && kind == K_EOC && imm[0];
   assign clr_fire    = fire && kind == K_WFE && wfe_upd;
   assign irq_set     = {fault_fetch, 2'b00, fault_op, done_hit | eoc_irq};

   assign tgt_we   = fire && kind == K_WRITE;
   assign tgt_data = imm;
   assign tgt_mask = mask_q;
   assign irq      = |(irq_st_q & irq_en_q);

   always_comb begin
      if (kind == K_JUMP) pc_nxt = jmp_abs ? imm[AW-1:0] : pc_q + imm[AW-1:0];
      else                pc_nxt = pc_q + AW'(INSTR_BYTES);
   end

   for (genvar e = 0; e < NEV; e++) begin : g_clr
      assign evt_clr[e] = clr_fire && ev_id == EVW'(e);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; susp_q <= 1'b0; stop_q <= 1'b0;
         prio_q <= '0; irq_st_q <= '0; irq_en_q <= '0;
         pc_q <= '0; end_q <= '0; mask_q <= '1; rcnt_q <= '0;
      end else if (rst_busy) begin
         rcnt_q <= rcnt_q - 1'b1;
         en_q <= 1'b0; susp_q <= 1'b0; stop_q <= 1'b0;
         pc_q <= '0; end_q <= '0; mask_q <= '1; irq_st_q <= '0;
      end else begin
         if (cfg_we) begin
            unique case (cfg_addr)
               REG_WRST:  if (cfg_wdata[0]) rcnt_q <= RCW'(RST_CYC);
               REG_EN:    en_q     <= cfg_wdata[0];
               REG_SUSP:  susp_q   <= cfg_wdata[0];
               REG_IRQEN: irq_en_q <= cfg_wdata[4:0] & IRQ_BITS;
               REG_END:   end_q    <= cfg_wdata[AW-1:0];
               REG_PRIO:  prio_q   <= cfg_wdata[PRIO_W-1:0];
               default: ;
            endcase
         end
         irq_st_q <= ((cfg_we && cfg_addr == REG_IRQ) ? irq_st_q & cfg_wdata[4:0]
                                                       : irq_st_q) | irq_set;
         if (cur_wr) begin
            pc_q   <= cfg_wdata[AW-1:0];
            stop_q <= 1'b0;
         end else begin
            if (fire) pc_q <= pc_nxt;
            if (done_hit || fault_fetch || fault_op) stop_q <= 1'b1;
         end
         if (fire && kind == K_MASK) mask_q <= imm;
         else if (tgt_we)            mask_q <= '1;
      end
   end

   always_comb begin
      unique case (cfg_addr)
         REG_WRST:  cfg_rdata = {31'b0, rst_busy};
         REG_EN:    cfg_rdata = {31'b0, en_q};
         REG_SUSP:  cfg_rdata = {31'b0, susp_q};
         REG_STAT:  cfg_rdata = {30'b0, susp_q, run};
         REG_IRQ:   cfg_rdata = {27'b0, irq_st_q};
         REG_IRQEN: cfg_rdata = {27'b0, irq_en_q};
         REG_CUR:   cfg_rdata = 32'(pc_q);
         REG_END:   cfg_rdata = 32'(end_q);
         REG_WTOK:  cfg_rdata = {wait_tok, 31'b0};
         REG_PRIO:  cfg_rdata = 32'(prio_q);
         default:   cfg_rdata = '0;
      endcase
   end

   // R4: after a write the mask is back to all ones
   a_r4_mask_restore: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_we |=> (mask_q == '1));
   // R5: no event is cleared while the thread is stalled on one
   a_r5_no_clear_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
      wait_tok |-> (evt_clr == '0));
   // R6: a suspended thread keeps its current address
   a_r6_susp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_q && !cfg_we && !rst_busy) |=> $stable(pc_q));
   // R10: a halted thread issues no target writes
   a_r10_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !cfg_we) |=> !tgt_we);
   // R12: warm reset keeps the memory and target ports quiet
   a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rst_busy |-> (!mem_req && !tgt_we && evt_clr == '0));
endmodule

// File: tb/test_cq_thread.sv
`timescale 1ns/1ps
module test_cq_thread;
   localparam int AW = 32, NEV = 32, RST_CYC = 4, LAT = 3;
   localparam logic [7:0] A_WRST = 8'h00, A_EN = 8'h04, A_SUSP = 8'h08, A_STAT = 8'h0C,
      A_IRQ = 8'h10, A_IRQEN = 8'h14, A_CUR = 8'h20, A_END = 8'h24, A_WTOK = 8'h30;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic mem_req, mem_valid = 1'b0, mem_err = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [63:0] mem_data = '0;
   logic tgt_we, irq;
   logic [4:0] tgt_subsys;
   logic [15:0] tgt_offs;
   logic [31:0] tgt_data, tgt_mask;
   logic [NEV-1:0] evt = '0, evt_clr;

   always #2 clk = ~clk;

   cq_thread #(.AW(AW), .NEV(NEV), .RST_CYC(RST_CYC), .PRIO_W(3)) i_cq_thread (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
      .mem_err(mem_err), .tgt_we(tgt_we), .tgt_subsys(tgt_subsys),
      .tgt_offs(tgt_offs), .tgt_data(tgt_data), .tgt_mask(tgt_mask),
      .evt_flags(evt), .evt_clr(evt_clr), .irq(irq)
   );

   int nvec = 0, nbad = 0;
   logic [63:0] mem [128];
   logic [84:0] expq [$];

   // memory model: one outstanding request, answered LAT cycles later
   int cnt = 0;
   logic [AW-1:0] raddr = '0;
   always @(posedge clk) begin
      mem_valid <= 1'b0;
      if (cnt == 1) begin
         mem_valid <= 1'b1;
         mem_err   <= raddr >= 32'h400;
         mem_data  <= (raddr >= 32'h400) ? 64'h0 : mem[raddr[9:3]];
      end
      if (cnt > 0) cnt <= cnt - 1;
      if (mem_req) begin cnt <= LAT; raddr <= mem_addr; end
   end

   // event source model: a flag drops when the thread clears it
   always @(posedge clk)
      for (int e = 0; e < NEV; e++) if (evt_clr[e]) evt[e] <= 1'b0;

   // per-clock comparison of target writes against the model queue (R2, R4)
   always @(negedge clk) begin
      if (rst_n && tgt_we) begin
         logic [84:0] got;
         got = {tgt_subsys, tgt_offs, tgt_data, tgt_mask};
         nvec++;
         if (expq.size() == 0) begin
            nbad++;
            $display("FAIL R2 unexpected write act=%h exp=none", got);
         end else begin
            logic [84:0] want;
            want = expq.pop_front();
            if (got !== want) begin
               nbad++;
               $display("FAIL R2/R4 write act=%h exp=%h", got, want);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [63:0] i_wr(input logic [4:0] s, input logic [15:0] o, input logic [31:0] d);
      return {8'h04, 3'b000, s, o, d};
   endfunction
   function automatic logic [63:0] i_wfe(input int ev, input logic w, input logic u);
      return {8'h20, 8'h00, 16'(ev), u, 15'b0, w, 14'b0, 1'b1};
   endfunction
   function automatic logic [84:0] ew(input logic [4:0] s, input logic [15:0] o,
                                      input logic [31:0] d, input logic [31:0] m);
      return {s, o, d, m};
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin : main
      logic [31:0] v, held;
      for (int i = 0; i < 128; i++) mem[i] = 64'h7F00_0000_0000_0000;
      // program A: mask, writes, relative and absolute jumps
      mem[0] = {32'h0200_0000, 32'h0000_FF00};
      mem[1] = i_wr(5'd3, 16'h0010, 32'h1234_5678);
      mem[2] = i_wr(5'd1, 16'h0020, 32'hAABB_CCDD);
      mem[3] = {32'h1000_0000, 32'h0000_0010};
      mem[5] = {32'h1000_0001, 32'h0000_0040};
      mem[8] = i_wr(5'd2, 16'h0004, 32'h0000_0001);
      // events program at 0x80
      mem[16] = i_wfe(2, 1'b0, 1'b1);
      mem[17] = {32'h4000_0000, 32'h0000_0001};
      mem[18] = i_wfe(5, 1'b1, 1'b1);
      mem[19] = i_wr(5'd4, 16'h0030, 32'h0000_0055);
      // suspend program at 0x100
      for (int i = 0; i < 4; i++) mem[32+i] = i_wr(5'd5, 16'(i), 32'hA0 + i);
      // refetch program: 0x140 must be dropped, 0x180 runs
      mem[40] = i_wr(5'd6, 16'h0000, 32'hDEAD);
      mem[48] = i_wr(5'd7, 16'h0008, 32'hBEEF);

      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      rd(A_EN, v);   chk("R1 enable", v, 0);
      rd(A_CUR, v);  chk("R1 cur addr", v, 0);
      rd(A_IRQ, v);  chk("R1 irq status", v, 0);
      rd(A_WRST, v); chk("R1 warm reset", v, 0);
      chk("R1 irq pin", {31'b0, irq}, 0);
      chk("R1 mem_req", {31'b0, mem_req}, 0);

      // R2 R3 R4 R7: program A
      expq.push_back(ew(5'd3, 16'h0010, 32'h1234_5678, 32'h0000_FF00));
      expq.push_back(ew(5'd1, 16'h0020, 32'hAABB_CCDD, 32'hFFFF_FFFF));
      expq.push_back(ew(5'd2, 16'h0004, 32'h0000_0001, 32'hFFFF_FFFF));
      wr(A_IRQEN, 32'h13);
      wr(A_END, 32'h48);
      wr(A_EN, 32'h1);
      idle(100);
      rd(A_CUR, v); chk("R7 stop at end", v, 32'h48);
      rd(A_IRQ, v); chk("R3 R7 done without error", v, 32'h1);
      chk("R7 irq pin", {31'b0, irq}, 1);
      chk("R2 all writes seen", expq.size(), 0);

      // R8 clear by writing zero
      wr(A_IRQ, 32'hFFFF_FFFF);
      rd(A_IRQ, v); chk("R8 write ones keeps", v, 32'h1);
      wr(A_IRQ, 32'h0);
      rd(A_IRQ, v); chk("R8 cleared", v, 0);
      chk("R8 irq pin low", {31'b0, irq}, 0);

      // R5 R13: events
      @(negedge clk); evt[2] = 1'b1;
      wr(A_END, 32'hA0);
      wr(A_CUR, 32'h80);
      idle(60);
      chk("R5 clear-only event", {31'b0, evt[2]}, 0);
      rd(A_WTOK, v); chk("R5 wait token", v, 32'h8000_0000);
      rd(A_CUR, v);  chk("R5 stalled addr", v, 32'h90);
      rd(A_IRQ, v);  chk("R13 eoc irq", v, 32'h1);
      expq.push_back(ew(5'd4, 16'h0030, 32'h55, 32'hFFFF_FFFF));
      @(negedge clk); evt[5] = 1'b1;
      idle(40);
      chk("R5 waited event cleared", {31'b0, evt[5]}, 0);
      rd(A_WTOK, v); chk("R5 token released", v, 0);
      rd(A_CUR, v);  chk("R5 ran to end", v, 32'hA0);
      chk("R5 write after wait", expq.size(), 0);

      // R6 suspend and resume
      wr(A_SUSP, 32'h1);
      wr(A_IRQ, 32'h0);
      wr(A_END, 32'h120);
      wr(A_CUR, 32'h100);
      idle(30);
      rd(A_STAT, v); chk("R6 status suspended", v & 32'h2, 32'h2);
      rd(A_CUR, v);  chk("R6 no progress", v, 32'h100);
      for (int i = 0; i < 4; i++) expq.push_back(ew(5'd5, 16'(i), 32'hA0 + i, 32'hFFFF_FFFF));
      wr(A_SUSP, 32'h0);
      idle(8);
      wr(A_SUSP, 32'h1);
      rd(A_CUR, held);
      idle(30);
      rd(A_CUR, v); chk("R6 frozen mid program", v, held);
      wr(A_SUSP, 32'h0);
      idle(80);
      rd(A_CUR, v); chk("R6 resumed to end", v, 32'h120);
      chk("R6 all writes", expq.size(), 0);

      // R9 refetch drops in-flight instruction
      expq.push_back(ew(5'd7, 16'h0008, 32'hBEEF, 32'hFFFF_FFFF));
      wr(A_IRQ, 32'h0);
      wr(A_END, 32'h188);
      wr(A_CUR, 32'h140);
      @(negedge clk);
      wr(A_CUR, 32'h180);
      idle(60);
      rd(A_CUR, v); chk("R9 restart address", v, 32'h188);
      rd(A_IRQ, v); chk("R9 clean done", v, 32'h1);
      chk("R9 stale write dropped", expq.size(), 0);

      // R10 undefined opcode
      wr(A_IRQ, 32'h0);
      wr(A_END, 32'h1D0);
      wr(A_CUR, 32'h1C0);
      idle(30);
      rd(A_IRQ, v); chk("R10 bad opcode bit", v, 32'h2);
      rd(A_CUR, v); chk("R10 halt addr", v, 32'h1C0);
      chk("R10 irq pin", {31'b0, irq}, 1);

      // R11 fetch error
      wr(A_IRQ, 32'h0);
      wr(A_END, 32'h500);
      wr(A_CUR, 32'h400);
      idle(30);
      rd(A_IRQ, v); chk("R11 fetch error bit", v, 32'h10);
      rd(A_CUR, v); chk("R11 halt addr", v, 32'h400);

      // R12 warm reset
      wr(A_WRST, 32'h1);
      rd(A_WRST, v); chk("R12 busy", v, 32'h1);
      idle(RST_CYC + 2);
      rd(A_WRST, v); chk("R12 self clear", v, 0);
      rd(A_EN, v);   chk("R12 enable cleared", v, 0);
      rd(A_CUR, v);  chk("R12 addr cleared", v, 0);
      rd(A_IRQ, v);  chk("R12 status cleared", v, 0);
      chk("R12 irq pin", {31'b0, irq}, 0);

      idle(5);
      chk("R2 no leftover writes", expq.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule